// File: doc/BRIEF.md
# Power-On Reset Pulse Generator

This block turns two reset causes into one clean, stretched processor reset. The first cause is a supply-good flag, already digitised by an external comparator. The second is an active-low manual reset request from a push-button or from other logic. While either cause is present, the reset is asserted. Once both causes have gone away, the reset stays asserted for a fixed number of clock cycles and then releases.

The manual request passes through a two-flop synchroniser. After that it shares the hold timer with the supply path. The hold timer therefore also filters contact bounce. Any return of a cause during the hold restarts the count from zero, so a bouncing button produces one long reset and never a train of short pulses.

Two reset outputs are driven from separate registers that are loaded in the same cycle. One is active-low and the other is active-high, so a processor of either polarity can be attached. The hold length is a parameter in clock cycles. The default corresponds to 200 ms at 100 MHz.

Top module: `por_pulse_gen`

## Requirements
- R1: While the register reset `rst` is high, and afterwards for as long as `supply_ok_i` stays low, `rst_n_o` is 0 and `rst_o` is 1.
- R2: If `supply_ok_i` is sampled low at a rising clock edge, `rst_n_o` is 0 after that same edge.
- R3: With `man_rst_n_i` high, `rst_n_o` rises at the HOLD_CYCLES-th rising edge that samples `supply_ok_i` high, counted from the first such edge. It is still 0 after the edge before that one.
- R4: A low level on `man_rst_n_i` asserts reset at the third rising edge that samples it, because of two synchroniser stages plus the output register. It does not assert reset earlier.
- R5: After `man_rst_n_i` returns high, with the supply good, `rst_n_o` rises at the (HOLD_CYCLES+2)-th rising edge that samples it high.
- R6: A manual input that bounces with high intervals shorter than HOLD_CYCLES keeps `rst_n_o` at 0 without a break, and the hold runs only from the final release.
- R7: `rst_o` is always the exact complement of `rst_n_o`.
- R8: A cause that reappears during the hold, even for one cycle, restarts the count, so release comes HOLD_CYCLES edges after the last edge on which a cause was sampled.
- R9: A falling edge of `rst_n_o` only follows a low `supply_ok_i` one edge earlier or a low `man_rst_n_i` three edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high register reset |
| supply_ok_i | input | 1 | Digitised supply-good flag, 1 when the supply is above threshold |
| man_rst_n_i | input | 1 | Active-low manual reset request, asynchronous |
| rst_n_o | output | 1 | Active-low processor reset |
| rst_o | output | 1 | Active-high processor reset, complement of rst_n_o |

## Verification
The hold counter is the only deep state, and a fault in it can only show up as the wrong release time. The bench therefore measures the exact edge at which `rst_n_o` rises after power-up, after a manual release and after a mid-hold glitch. A count that is off by one, or that fails to restart, is detected within HOLD_CYCLES+2 cycles of the event. A broken synchroniser or cause path shows up within three edges as a wrong assertion latency. A bounce that leaks through shows up as a 1 on `rst_n_o` during the bounce window. A mismatch between the two output registers shows up at every sample.

// File: rtl/por_pkg.sv
package por_pkg;

    // Hold-state of the reset generator.
    typedef enum logic {
        ST_HOLD = 1'b0,   // reset asserted (cause present or stretch running)
        ST_RUN  = 1'b1    // reset released
    } por_state_e;

    // Reset causes after synchronisation.
    typedef struct packed {
        logic supply_low;
        logic manual;
    } por_cause_t;

    // Outputs of the reset stage.
    typedef struct packed {
        logic rst_n;
        logic rst;
    } por_out_t;

    // Counter width needed to count 0 .. n-1, at least one bit.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic any_cause(input por_cause_t c);
        return c.supply_low | c.manual;
    endfunction

endpackage

// File: rtl/por_sync.sv
module por_sync #(
    parameter int unsigned STAGES   = 2,
    parameter logic        INIT_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= INIT_VAL;
                    else     chain_q[0] <= d_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= INIT_VAL;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/por_hold_timer.sv
module por_hold_timer
    import por_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 20_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  por_cause_t cause_i,
    output logic       hold_nxt_o
);

    localparam int unsigned CNT_W = cnt_width(HOLD_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

    por_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (any_cause(cause_i)) begin
            state_d = ST_HOLD;
            cnt_d   = '0;
        end else if (state_q == ST_HOLD) begin
            if (cnt_q == LAST) begin
                state_d = ST_RUN;
                cnt_d   = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign hold_nxt_o = (state_d == ST_HOLD);

endmodule

// File: rtl/por_out_stage.sv
module por_out_stage
    import por_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hold_i,
    output por_out_t out_o
);

    // Two independent flops, both loaded from the same next state.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_o.rst_n <= 1'b0;
            out_o.rst   <= 1'b1;
        end else begin
            out_o.rst_n <= ~hold_i;
            out_o.rst   <= hold_i;
        end
    end

endmodule

// File: rtl/por_pulse_gen.sv
module por_pulse_gen
    import por_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 20_000_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok_i,
    input  logic man_rst_n_i,
    output logic rst_n_o,
    output logic rst_o
);

    logic       man_n_sync;
    logic       hold_nxt;
    por_cause_t cause;
    por_out_t   outs;

    por_sync #(
        .STAGES   (SYNC_STAGES),
        .INIT_VAL (1'b1)
    ) i_man_sync (
        .clk (clk),
        .rst (rst),
        .d_i (man_rst_n_i),
        .q_o (man_n_sync)
    );

    always_comb begin
        cause.supply_low = ~supply_ok_i;
        cause.manual     = ~man_n_sync;
    end

    por_hold_timer #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) i_timer (
        .clk        (clk),
        .rst        (rst),
        .cause_i    (cause),
        .hold_nxt_o (hold_nxt)
    );

    por_out_stage i_out (
        .clk    (clk),
        .rst    (rst),
        .hold_i (hold_nxt),
        .out_o  (outs)
    );

    assign rst_n_o = outs.rst_n;
    assign rst_o   = outs.rst;

endmodule

// File: rtl/por_pulse_gen_chk.sv
module por_pulse_gen_chk #(
    parameter int unsigned HOLD_CYCLES = 20_000_000
) (
    input logic clk,
    input logic rst,
    input logic supply_ok_i,
    input logic man_rst_n_i,
    input logic rst_n_o,
    input logic rst_o
);

    // Consecutive cycles with no raw cause, saturating at HOLD_CYCLES.
    int unsigned quiet_q;

    always_ff @(posedge clk) begin
        if (rst)                             quiet_q <= 0;
        else if (!supply_ok_i || !man_rst_n_i) quiet_q <= 0;
        else if (quiet_q < HOLD_CYCLES)      quiet_q <= quiet_q + 1;
    end

    // R7
    a_r7_complement: assert property (@(posedge clk) disable iff (rst)
        rst_o == !rst_n_o);

    // R2
    a_r2_supply_low_asserts: assert property (@(posedge clk) disable iff (rst)
        !supply_ok_i |=> !rst_n_o);

    // R3 / R8
    a_r3_release_after_quiet: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_n_o) |-> (quiet_q >= HOLD_CYCLES));

    // R9
    a_r9_fall_has_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_n_o) |-> (!$past(supply_ok_i) || !$past(man_rst_n_i, 3)));

endmodule

bind por_pulse_gen por_pulse_gen_chk #(.HOLD_CYCLES(HOLD_CYCLES)) i_chk (.*);

// File: tb/test_por_pulse_gen.sv
module test_por_pulse_gen;

    localparam int unsigned H = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok_i = 1'b0;
    logic man_rst_n_i = 1'b1;
    logic rst_n_o, rst_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    por_pulse_gen #(.HOLD_CYCLES(H)) i_por_pulse_gen (
        .clk         (clk),
        .rst         (rst),
        .supply_ok_i (supply_ok_i),
        .man_rst_n_i (man_rst_n_i),
        .rst_n_o     (rst_n_o),
        .rst_o       (rst_o)
    );

    // Advance n rising edges, then settle to the following falling edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic exp_n);
        total++;
        if (rst_n_o !== exp_n) begin
            bad++;
            $display("FAIL %s: rst_n_o=%b expected %b at %0t", req, rst_n_o, exp_n, $time);
        end
        total++;
        if (rst_o !== ~exp_n) begin
            bad++;
            $display("FAIL R7 (%s): rst_o=%b expected %b at %0t", req, rst_o, ~exp_n, $time);
        end
    endtask

    task automatic t_reset_state;
        step(3);
        check("R1 during reset", 1'b0);
        rst = 1'b0;
        step(20);
        check("R1 supply low after reset", 1'b0);
    endtask

    task automatic t_power_up;
        supply_ok_i = 1'b1;
        step(H - 1);
        check("R3 before release", 1'b0);
        step(1);
        check("R3 release", 1'b1);
        step(5);
        check("R3 stays released", 1'b1);
    endtask

    task automatic t_supply_dip;
        supply_ok_i = 1'b0;
        step(1);
        check("R2 immediate assert", 1'b0);
        step(4);
        supply_ok_i = 1'b1;
        step(H - 1);
        check("R3 dip hold", 1'b0);
        step(1);
        check("R3 dip release", 1'b1);
    endtask

    task automatic t_manual;
        man_rst_n_i = 1'b0;
        step(2);
        check("R4 not yet asserted", 1'b1);
        step(1);
        check("R4 asserted", 1'b0);
        step(10);
        man_rst_n_i = 1'b1;
        step(H + 1);
        check("R5 before release", 1'b0);
        step(1);
        check("R5 release", 1'b1);
    endtask

    task automatic t_bounce;
        man_rst_n_i = 1'b0;
        step(12);
        for (int b = 0; b < 5; b++) begin
            man_rst_n_i = 1'b1;
            for (int c = 0; c < 3; c++) begin
                step(1);
                check("R6 bounce high", 1'b0);
            end
            man_rst_n_i = 1'b0;
            for (int c = 0; c < 2; c++) begin
                step(1);
                check("R6 bounce low", 1'b0);
            end
        end
        man_rst_n_i = 1'b1;
        step(H + 1);
        check("R6 final hold", 1'b0);
        step(1);
        check("R6 final release", 1'b1);
    endtask

    task automatic t_restart;
        supply_ok_i = 1'b0;
        step(3);
        supply_ok_i = 1'b1;
        step(H - 2);
        check("R8 mid hold", 1'b0);
        supply_ok_i = 1'b0;
        step(1);
        supply_ok_i = 1'b1;
        step(H - 1);
        check("R8 restarted, not released", 1'b0);
        step(1);
        check("R8 release after restart", 1'b1);
    endtask

    initial begin
        t_reset_state();
        t_power_up();
        t_supply_dip();
        t_manual();
        t_bounce();
        t_restart();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule